// File: doc/BRIEF.md
# Erase-before-write page array

A synthesizable, scaled-down model of a page-organised non-volatile storage array. Storage is divided into blocks, each block into pages, and each page carries a data area followed by a small spare area. A single synchronous request port offers three operations: read a whole page, program a whole page, and erase a whole block. The array behaves like real cell storage and not like RAM. Programming can only drive bits from one to zero. Only an erase of the full block brings them back to one.

Each block keeps an erase counter. Once the counter passes a configurable endurance limit, an erase leaves a byte stuck at zero. That byte is the bad-block marker in the first spare byte of the block's first page, so the block then reads as bad. Program and erase requests aimed at a bad block are refused with an error and change nothing. A side query port reports the bad flag and erase count of any block at any time. The model is intended as a device under test or as a stand-in for flash behind a controller under development.

Top module: `nand_array`

## Requirements
- R1: After reset every byte of every page (data and spare) reads 8'hFF, every erase count is 0, and busy and done are low.
- R2: A request is taken when start is high, op is not 2'b00 and busy is low (op 2'b01 read, 2'b10 program, 2'b11 erase). busy then stays high for exactly BUSY_CYCLES cycles, followed by a one-cycle done pulse. A start with op 2'b00 is ignored.
- R3: A read returns the addressed page on rdata with page byte i on bits [8i+7:8i]. Bytes 0 to DATA_BYTES-1 are the data area and the following SPARE_BYTES bytes are the spare area.
- R4: A program stores the bitwise AND of the stored page and wdata, so no bit ever returns from 0 to 1.
- R5: An erase of a good block sets every byte of all its pages, spare included, to 8'hFF, leaves other blocks untouched and adds one to that block's erase count.
- R6: A block is bad when byte DATA_BYTES (first spare byte) of its page 0 differs from 8'hFF. qbad reports this for block qblk, and once set it stays set.
- R7: An erase that starts with the block's count already at ERASE_LIMIT or more leaves byte DATA_BYTES of page 0 at 8'h00, so the block becomes bad after its count passes ERASE_LIMIT.
- R8: Program or erase of a bad block ends with err high during the done pulse, leaves the contents and the count unchanged. A read of a bad block completes with err low.
- R9: qcount gives the erase count of block qblk, and it never exceeds ERASE_LIMIT+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe |
| op | input | 2 | Operation: 01 read, 10 program, 11 erase |
| blk | input | BW | Target block |
| pg | input | PGW | Target page within the block |
| wdata | input | PW | Page contents to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request rejected, valid with done |
| rdata | output | PW | Page read result, updated with done of a read |
| qblk | input | BW | Block selected for status query |
| qbad | output | 1 | Selected block is bad |
| qcount | output | CW | Erase count of selected block |

## Verification
The assertions assume that start is held low while reset is active and that the block and page inputs stay within BLOCKS and PAGES. They also assume ERASE_LIMIT is small enough for the counter width to hold ERASE_LIMIT+1. The bench drives only in-range addresses, keeps start low through reset, and issues each request as a single-cycle strobe on the falling edge. It then waits for done, so requests overlap a busy operation only where it deliberately checks that they are ignored.

// File: rtl/nand_array.sv
module nand_array #(
  parameter int DATA_BYTES  = 16,
  parameter int SPARE_BYTES = 4,
  parameter int PAGES       = 4,
  parameter int BLOCKS      = 4,
  parameter int BUSY_CYCLES = 4,
  parameter int ERASE_LIMIT = 3,
  localparam int PB  = DATA_BYTES + SPARE_BYTES,
  localparam int PW  = PB * 8,
  localparam int BW  = (BLOCKS > 1) ? $clog2(BLOCKS) : 1,
  localparam int PGW = (PAGES > 1) ? $clog2(PAGES) : 1,
  localparam int CW  = $clog2(ERASE_LIMIT + 2)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [1:0]     op,
  input  logic [BW-1:0]  blk,
  input  logic [PGW-1:0] pg,
  input  logic [PW-1:0]  wdata,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic [PW-1:0]  rdata,
  input  logic [BW-1:0]  qblk,
  output logic           qbad,
  output logic [CW-1:0]  qcount
);
  localparam int NB = BLOCKS * PAGES * PB;
  localparam int BBYTES = PAGES * PB;
  localparam int AW = $clog2(NB + 1);
  localparam int TW = $clog2(BUSY_CYCLES + 1);
  localparam logic [1:0] OP_RD = 2'b01, OP_PR = 2'b10, OP_ER = 2'b11;

  logic [7:0]     mem [NB];
  logic [CW-1:0]  ecnt [BLOCKS];
  logic [BLOCKS-1:0] bad_v;
  logic [1:0]     r_op;
  logic [BW-1:0]  r_blk;
  logic [PGW-1:0] r_pg;
  logic [PW-1:0]  r_wd;
  logic [TW-1:0]  tmr;
  logic [AW-1:0]  pbase, bbase;

  for (genvar b = 0; b < BLOCKS; b++) begin : g_bad
    assign bad_v[b] = mem[b * BBYTES + DATA_BYTES] != 8'hFF;
    // R6
    always @(posedge clk) begin
      bad_sticky_chk: assert property (disable iff (rst) bad_v[b] |=> bad_v[b]);
    end
    // R7
    always @(posedge clk) begin
      worn_bad_chk: assert property (disable iff (rst) (ecnt[b] > CW'(ERASE_LIMIT)) |-> bad_v[b]);
    end
    // R9
    always @(posedge clk) begin
      count_bound_chk: assert property (disable iff (rst) ecnt[b] <= CW'(ERASE_LIMIT + 1));
    end
  end

  assign pbase  = AW'((int'(r_blk) * PAGES + int'(r_pg)) * PB);
  assign bbase  = AW'(int'(r_blk) * BBYTES);
  assign qbad   = bad_v[qblk];
  assign qcount = ecnt[qblk];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
      rdata <= '0;
      tmr   <= '0;
      r_op  <= '0;
      r_blk <= '0;
      r_pg  <= '0;
      r_wd  <= '0;
      for (int i = 0; i < NB; i++) mem[i] <= 8'hFF;
      for (int b = 0; b < BLOCKS; b++) ecnt[b] <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (!busy) begin
        if (start && op != 2'b00) begin
          busy  <= 1'b1;
          tmr   <= TW'(BUSY_CYCLES - 1);
          r_op  <= op;
          r_blk <= blk;
          r_pg  <= pg;
          r_wd  <= wdata;
        end
      end else if (tmr != '0) begin
        tmr <= tmr - 1'b1;
      end else begin
        busy <= 1'b0;
        done <= 1'b1;
        case (r_op)
          OP_RD: for (int i = 0; i < PB; i++) rdata[8*i +: 8] <= mem[pbase + AW'(i)];
          OP_PR: begin
            if (bad_v[r_blk]) err <= 1'b1;
            else for (int i = 0; i < PB; i++)
              mem[pbase + AW'(i)] <= mem[pbase + AW'(i)] & r_wd[8*i +: 8];
          end
          OP_ER: begin
            if (bad_v[r_blk]) err <= 1'b1;
            else begin
              ecnt[r_blk] <= ecnt[r_blk] + 1'b1;
              for (int i = 0; i < BBYTES; i++) mem[bbase + AW'(i)] <= 8'hFF;
              if (ecnt[r_blk] >= CW'(ERASE_LIMIT)) mem[bbase + AW'(DATA_BYTES)] <= 8'h00;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  always @(posedge clk) begin
    done_pulse_chk: assert property (disable iff (rst) done |=> !done);
  end
  // R2
  always @(posedge clk) begin
    done_idle_chk: assert property (disable iff (rst) done |-> !busy);
  end
  // R2
  always @(posedge clk) begin
    busy_cause_chk: assert property (disable iff (rst) $rose(busy) |-> $past(start && op != 2'b00));
  end
  // R8
  always @(posedge clk) begin
    err_with_done_chk: assert property (disable iff (rst) err |-> done);
  end
endmodule

// File: tb/tb_nand_array.sv
module tb_nand_array;
  localparam int CLK_PERIOD = 10;
  localparam int DB = 4, SB = 2, PG = 2, NBK = 4, BUSY = 3, LIM = 2;
  localparam int PB = DB + SB, PW = PB * 8, BW = 2, PGW = 1, CW = $clog2(LIM + 2);

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [1:0] op = 2'b00;
  logic [BW-1:0] blk = '0, qblk = '0;
  logic [PGW-1:0] pg = '0;
  logic [PW-1:0] wdata = '0;
  logic busy, done, err, qbad;
  logic [PW-1:0] rdata;
  logic [CW-1:0] qcount;

  nand_array #(.DATA_BYTES(DB), .SPARE_BYTES(SB), .PAGES(PG), .BLOCKS(NBK),
               .BUSY_CYCLES(BUSY), .ERASE_LIMIT(LIM)) dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .blk(blk), .pg(pg), .wdata(wdata),
    .busy(busy), .done(done), .err(err), .rdata(rdata),
    .qblk(qblk), .qbad(qbad), .qcount(qcount));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] m [NBK][PG][PB];
  int mc [NBK];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit mbad(input int b);
    return m[b][0][DB] != 8'hFF;
  endfunction

  function automatic logic [PW-1:0] mpage(input int b, input int p);
    logic [PW-1:0] v;
    for (int i = 0; i < PB; i++) v[8*i +: 8] = m[b][p][i];
    return v;
  endfunction

  function automatic logic [PW-1:0] pat(input int b, input int p, input int k);
    logic [PW-1:0] v;
    for (int i = 0; i < PB; i++)
      v[8*i +: 8] = (p == 0 && i == DB) ? 8'hFF : 8'((b*53 + p*29 + i*17 + k*91) ^ 8'hA5);
    return v;
  endfunction

  task automatic do_op(input logic [1:0] o, input int b, input int p,
                       input logic [PW-1:0] wd, input string tag);
    logic [PW-1:0] erd;
    logic eer;
    int cyc;
    eer = 1'b0;
    erd = mpage(b, p);
    if (o == 2'b10) begin
      if (mbad(b)) eer = 1'b1;
      else for (int i = 0; i < PB; i++) m[b][p][i] = m[b][p][i] & wd[8*i +: 8];
    end else if (o == 2'b11) begin
      if (mbad(b)) eer = 1'b1;
      else begin
        mc[b]++;
        for (int q = 0; q < PG; q++) for (int i = 0; i < PB; i++) m[b][q][i] = 8'hFF;
        if (mc[b] > LIM) m[b][0][DB] = 8'h00;
      end
    end
    @(negedge clk);
    start = 1'b1; op = o; blk = BW'(b); pg = PGW'(p); wdata = wd;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done) begin
      if (busy) cyc++;
      @(negedge clk);
    end
    check({tag, " R2 busy cycles"}, 64'(cyc), 64'(BUSY));
    check({tag, " R8 err"}, 64'(err), 64'(eer));
    if (o == 2'b01) check({tag, " R3 rdata"}, 64'(rdata), 64'(erd));
  endtask

  task automatic check_status(input string tag);
    for (int b = 0; b < NBK; b++) begin
      qblk = BW'(b);
      #1;
      check({tag, " R6 qbad"}, 64'(qbad), 64'(mbad(b)));
      check({tag, " R9 qcount"}, 64'(qcount), 64'(mc[b]));
    end
  endtask

  task automatic read_all(input string tag);
    for (int b = 0; b < NBK; b++)
      for (int p = 0; p < PG; p++) do_op(2'b01, b, p, '0, tag);
  endtask

  initial begin
    for (int b = 0; b < NBK; b++) begin
      mc[b] = 0;
      for (int p = 0; p < PG; p++) for (int i = 0; i < PB; i++) m[b][p][i] = 8'hFF;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 done", 64'(done), 64'd0);
    check_status("R1 reset");
    read_all("R1 erased");

    // R2: op 00 ignored
    @(negedge clk);
    start = 1'b1; op = 2'b00;
    @(negedge clk);
    start = 1'b0;
    check("R2 op00 busy", 64'(busy), 64'd0);

    // R4: program then AND with second pattern, every page
    for (int b = 0; b < NBK; b++)
      for (int p = 0; p < PG; p++) begin
        do_op(2'b10, b, p, pat(b, p, 0), "R4 prog1");
        do_op(2'b01, b, p, '0, "R4 read1");
        do_op(2'b10, b, p, pat(b, p, 1), "R4 prog2");
        do_op(2'b01, b, p, '0, "R4 and");
      end

    // R2: start while busy is ignored (program of block 3 page 1 to zeros)
    @(negedge clk);
    start = 1'b1; op = 2'b01; blk = 2'd0; pg = 1'b0;
    @(negedge clk);
    start = 1'b1; op = 2'b10; blk = 2'd3; pg = 1'b1; wdata = '0;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    do_op(2'b01, 3, 1, '0, "R2 start during busy ignored");

    // R5: erase one block, others unchanged
    do_op(2'b11, 0, 0, '0, "R5 erase");
    read_all("R5 after erase");
    check_status("R5 count");

    // R7: wear block 1 past limit
    for (int k = 0; k <= LIM; k++) begin
      do_op(2'b10, 1, 1, pat(1, 1, k + 2), "R7 prog before erase");
      do_op(2'b11, 1, 0, '0, "R7 erase");
      check_status("R7 wear");
      do_op(2'b01, 1, 0, '0, "R7 page0");
      do_op(2'b01, 1, 1, '0, "R7 page1");
    end

    // R8: bad block rejects program and erase
    do_op(2'b10, 1, 1, '0, "R8 prog bad");
    do_op(2'b01, 1, 1, '0, "R8 unchanged");
    do_op(2'b11, 1, 0, '0, "R8 erase bad");
    check_status("R8 count kept");

    // R6: mark block 2 bad through its spare byte
    begin
      logic [PW-1:0] mk;
      mk = '1;
      mk[8*DB +: 8] = 8'h00;
      do_op(2'b10, 2, 0, mk, "R6 mark");
    end
    check_status("R6 marked");
    do_op(2'b11, 2, 0, '0, "R6 erase rejected");
    do_op(2'b01, 2, 0, '0, "R8 read bad ok");
    check_status("R6 sticky");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R2 actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule